// File: doc/BRIEF.md
# Masked Round-Robin Channel Poller

The poller serves up to eighteen receive channels. Each channel holds one data word and raises a ready flag while that word is waiting. A rotating pointer visits the channels one at a time. When the pointer lands on a channel that software has enabled and that has its ready flag set, the poller copies the word into an internal dual-port buffer. The buffer entry also records the channel number. In the next clock the poller pulses that channel's acknowledge, which frees the channel's source register.

Software controls the poller with one configuration write. That write loads a per-channel enable mask and a global run bit together. Both reset to zero, so after reset no channel is served until software sets the run bit and at least one mask bit. The buffer has a simple first-word-fall-through read port. When the buffer is full, the poller holds its pointer on the waiting channel and gives no acknowledge until a read frees space.

Top module: `rr_poller`

## Requirements
- R1: After reset the run bit and every mask bit are zero, `ch_ack` is all zero, `rd_empty` is 1 and `buf_full` is 0.
- R2: While the run bit is 0, or while the mask bit of a channel is 0, that channel is never acknowledged and nothing from it enters the buffer, even with its ready flag set.
- R3: A channel whose mask bit is 1 and whose ready flag is 1 while the run bit is 1 has its word stored in the buffer. The entry holds that word on `rd_word` and the channel index (0 to NCH-1) on `rd_tag`.
- R4: Each stored word is followed by exactly one acknowledge pulse. The pulse is one clock wide, goes to the served channel only, and comes in the clock after the buffer write. At most one `ch_ack` bit is high in any clock, and an acknowledged channel is not acknowledged again in the next clock.
- R5: A disabled channel keeps its ready flag untouched, because it is never acknowledged. Setting its mask bit later lets it be served.
- R6: The pointer visits channels in ascending index order and wraps from NCH-1 to 0. With every channel ready and enabled, consecutive buffer entries carry consecutive tags modulo NCH, and each channel appears once per turn.
- R7: While the buffer holds 2**AW entries, `buf_full` is 1 and there are no writes and no acknowledges. The pending channel is served after a read frees space.
- R8: The read port is first-word-fall-through. `rd_word` and `rd_tag` show the oldest entry while `rd_empty` is 0, and `rd_en` pops that entry. An `rd_en` while the buffer is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Loads `cfg_run` and `cfg_mask` |
| cfg_run | input | 1 | Global run bit value |
| cfg_mask | input | NCH | Channel enable mask value, bit i enables channel i |
| ch_rdy | input | NCH | Per-channel data-ready flags |
| ch_data | input | NCH*DW | Channel words, channel i at bits [i*DW +: DW] |
| ch_ack | output | NCH | One-clock acknowledge per channel |
| rd_en | input | 1 | Pop the oldest buffer entry |
| rd_empty | output | 1 | Buffer holds no entry |
| buf_full | output | 1 | Buffer holds 2**AW entries |
| rd_word | output | DW | Data word of the oldest entry |
| rd_tag | output | $clog2(NCH) | Channel index of the oldest entry |

## Verification
The assertions assume that a channel's source behaves like a holding register. Its ready flag stays high, with its word steady, until the channel is acknowledged, and the flag drops in the clock after the acknowledge. Under that assumption one ready word produces exactly one buffer entry and one pulse. The bench's source model follows this rule: it clears a channel's flag at the edge where it sees that channel's acknowledge, and it raises flags only on falling edges. Configuration writes and reads are also driven on falling edges, so every input is steady at the rising edge that samples it.

// File: rtl/rr_poller.sv
module rr_poller #(
  parameter int NCH = 18,
  parameter int DW  = 32,
  parameter int AW  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic                     cfg_run,
  input  logic [NCH-1:0]           cfg_mask,
  input  logic [NCH-1:0]           ch_rdy,
  input  logic [NCH*DW-1:0]        ch_data,
  output logic [NCH-1:0]           ch_ack,
  input  logic                     rd_en,
  output logic                     rd_empty,
  output logic                     buf_full,
  output logic [DW-1:0]            rd_word,
  output logic [$clog2(NCH)-1:0]   rd_tag
);
  localparam int TW    = $clog2(NCH);
  localparam int DEPTH = 1 << AW;

  logic           run_q;
  logic [NCH-1:0] mask_q;
  logic [TW-1:0]  ptr;
  logic           ack_ph;
  logic [AW-1:0]  wp, rp;
  logic [AW:0]    cnt;

  logic [DW-1:0] mem_d [DEPTH];
  logic [TW-1:0] mem_t [DEPTH];

  wire last    = (ptr == TW'(NCH-1));
  wire hit     = run_q && !ack_ph && mask_q[ptr] && ch_rdy[ptr];
  wire wr_fire = hit && !buf_full;
  wire rd_fire = rd_en && !rd_empty;

  assign buf_full = (cnt == (AW+1)'(DEPTH));
  assign rd_empty = (cnt == '0);
  assign rd_word  = mem_d[rp];
  assign rd_tag   = mem_t[rp];
  assign ch_ack   = ack_ph ? (NCH'(1) << ptr) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mask_q <= '0;
    end else if (cfg_wr) begin
      run_q  <= cfg_run;
      mask_q <= cfg_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      ack_ph <= 1'b0;
    end else if (ack_ph) begin
      ack_ph <= 1'b0;
      ptr    <= last ? '0 : ptr + TW'(1);
    end else if (wr_fire) begin
      ack_ph <= 1'b1;
    end else if (run_q && !hit) begin
      ptr    <= last ? '0 : ptr + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      mem_d[wp] <= ch_data[ptr*DW +: DW];
      mem_t[wp] <= ptr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_fire) wp <= wp + AW'(1);
      if (rd_fire) rp <= rp + AW'(1);
      cnt <= cnt + (AW+1)'(wr_fire) - (AW+1)'(rd_fire);
    end
  end

  assert_ack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_ack));

  assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ack != '0) |=> (ch_ack == '0));

  assert_ack_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ack != '0) |-> $past(wr_fire));

  assert_ack_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ack != '0) |-> ((ch_ack & $past(mask_q)) != '0));

  assert_run_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (ch_ack == '0));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !rd_en) |=> (buf_full && ch_ack == '0));

  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_empty && !hit) |=> rd_empty);
endmodule

// File: tb/rr_poller_bench.sv
module rr_poller_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 18;
  localparam int DW  = 32;
  localparam int AW  = 4;
  localparam int TW  = $clog2(NCH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_run = 1'b0;
  logic [NCH-1:0] cfg_mask = '0;
  logic [NCH-1:0] ch_rdy = '0;
  logic [NCH*DW-1:0] ch_data = '0;
  logic [NCH-1:0] ch_ack;
  logic rd_en = 1'b0;
  logic rd_empty, buf_full;
  logic [DW-1:0] rd_word;
  logic [TW-1:0] rd_tag;

  int checks = 0, failures = 0;
  int ack_cnt [NCH];
  logic [NCH-1:0] prev_ack = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_poller #(.NCH(NCH), .DW(DW), .AW(AW)) u_rr_poller (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_run(cfg_run), .cfg_mask(cfg_mask),
    .ch_rdy(ch_rdy), .ch_data(ch_data), .ch_ack(ch_ack), .rd_en(rd_en),
    .rd_empty(rd_empty), .buf_full(buf_full), .rd_word(rd_word), .rd_tag(rd_tag));

  always @(posedge clk)
    for (int i = 0; i < NCH; i++) if (ch_ack[i]) ch_rdy[i] <= 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(ch_ack) > 1 || (ch_ack != '0 && prev_ack != '0)) begin
        failures++;
        $display("FAIL R4 ack shape actual=%h previous=%h expected one-clock one-hot", ch_ack, prev_ack);
      end
      for (int i = 0; i < NCH; i++) if (ch_ack[i]) ack_cnt[i]++;
    end
    prev_ack = ch_ack;
  end

  function automatic logic [DW-1:0] pat(int ch);
    return 32'hA5000000 ^ (ch * 32'h01010101) ^ 32'h00C3;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(bit run, logic [NCH-1:0] m);
    @(negedge clk); cfg_run = run; cfg_mask = m; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic load(int ch, logic [DW-1:0] d);
    ch_data[ch*DW +: DW] = d;
    ch_rdy[ch] = 1'b1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int total_acks();
    int s = 0;
    for (int i = 0; i < NCH; i++) s += ack_cnt[i];
    return s;
  endfunction

  task automatic pop(output int tag, output logic [DW-1:0] w);
    int g = 0;
    while (rd_empty && g < 100) begin @(negedge clk); g++; end
    chk(!rd_empty, "R8 entry available", rd_empty, 0);
    tag = int'(rd_tag); w = rd_word;
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk(ch_ack == '0, "R1 ack idle", ch_ack, 0);
    chk(rd_empty == 1'b1, "R1 empty", rd_empty, 1);
    chk(buf_full == 1'b0, "R1 not full", buf_full, 0);
    load(3, pat(3));
    idle(40);
    chk(ack_cnt[3] == 0, "R1 zero mask/run serves nothing", ack_cnt[3], 0);
  endtask

  task automatic t_gating();
    int tag; logic [DW-1:0] w;
    cfg(1'b0, '1);
    idle(40);
    chk(ack_cnt[3] == 0 && rd_empty, "R2 run off", ack_cnt[3], 0);
    cfg(1'b1, '0);
    idle(40);
    chk(ack_cnt[3] == 0 && rd_empty, "R2 mask off", ack_cnt[3], 0);
    cfg(1'b1, NCH'(1) << 3);
    idle(40);
    chk(ack_cnt[3] == 1, "R4 single ack", ack_cnt[3], 1);
    chk(ch_rdy[3] == 1'b0, "R4 source freed", ch_rdy[3], 0);
    pop(tag, w);
    chk(tag == 3, "R3 tag", tag, 3);
    chk(w == pat(3), "R3 word", w, pat(3));
    chk(rd_empty, "R8 empty after pop", rd_empty, 1);
  endtask

  task automatic t_masked();
    int tag; logic [DW-1:0] w;
    cfg(1'b1, NCH'(1) << 7);
    load(5, pat(5)); load(7, pat(7));
    idle(60);
    chk(ack_cnt[5] == 0, "R5 disabled not acked", ack_cnt[5], 0);
    chk(ch_rdy[5] == 1'b1, "R5 flag untouched", ch_rdy[5], 1);
    pop(tag, w);
    chk(tag == 7 && w == pat(7), "R3 enabled entry", tag, 7);
    chk(rd_empty, "R5 nothing from disabled channel", rd_empty, 1);
    cfg(1'b1, (NCH'(1) << 7) | (NCH'(1) << 5));
    idle(40);
    pop(tag, w);
    chk(tag == 5 && w == pat(5), "R5 served after enable", tag, 5);
  endtask

  task automatic t_empty_read();
    int tag; logic [DW-1:0] w;
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk(rd_empty, "R8 empty read ignored", rd_empty, 1);
    cfg(1'b1, NCH'(1));
    load(0, 32'h1234_5678);
    idle(40);
    pop(tag, w);
    chk(tag == 0 && w == 32'h1234_5678, "R8 next entry intact", w, 32'h1234_5678);
  endtask

  task automatic t_rotate_full();
    int tag, prev; logic [DW-1:0] w;
    int base;
    bit [NCH-1:0] seen = '0;
    cfg(1'b0, '1);
    for (int i = 0; i < NCH; i++) load(i, pat(i));
    base = total_acks();
    cfg(1'b1, '1);
    idle(120);
    chk(buf_full, "R7 full flag", buf_full, 1);
    chk(total_acks() - base == (1 << AW), "R7 acks stop at depth", total_acks() - base, 1 << AW);
    chk($countones(ch_rdy) == NCH - (1 << AW), "R7 pending flags kept", $countones(ch_rdy), NCH - (1 << AW));
    prev = -1;
    for (int k = 0; k < NCH; k++) begin
      pop(tag, w);
      if (prev >= 0)
        chk(tag == (prev + 1) % NCH, "R6 ascending wrap order", tag, (prev + 1) % NCH);
      chk(w == pat(tag), "R3 word per tag", w, pat(tag));
      seen[tag] = 1'b1;
      prev = tag;
      idle(3);
    end
    chk(seen == '1, "R6 each channel once", seen, {NCH{1'b1}});
    chk(rd_empty && ch_rdy == '0, "R7 stalled channels drained", ch_rdy, 0);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) ack_cnt[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gating();
    t_masked();
    t_empty_read();
    t_rotate_full();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule